// File: doc/BRIEF.md
# Programmable-Length Serial Shift Register

This block is a serial delay line of one to sixty-four bits. A six-bit binary length code selects the active length as the code value plus one. A select line picks which of two serial data inputs feeds the first stage. Tying one data input to the output turns the block into a recirculating loop.

Shifts are requested through two clock-qualifier pins, which are sampled by the system clock. The first pin shifts on its rising edge, but only while the second pin is low. The second pin shifts on its falling edge, but only while the first pin is high. Each pin therefore gates the other.

A master clear input empties the register at once and forces the output low. The block drives the serial output and its complement. The qualifier pins are asynchronous to the system clock and are synchronized inside the block. The data and select inputs are sampled on the system clock edge that performs a shift. They must be held stable from the qualifier edge until the shift has taken place, which is about four system clocks later.

Top module: `prog_len_shreg`

## Requirements
- R1: With length code N (0 to 63), a bit shifted in appears on `q_o` after exactly N+1 shift events. Code 0 gives a one-bit register, so the bit appears after the shift that captured it.
- R2: When `src_sel_i` is 0, `din_a_i` is shifted in. When `src_sel_i` is 1, `din_b_i` is shifted in.
- R3: A rising edge on `cp_up_i` causes one shift while `cp_dn_i` is low. A rising edge on `cp_up_i` while `cp_dn_i` is high causes none. A falling edge on `cp_up_i` never causes a shift.
- R4: A falling edge on `cp_dn_i` causes one shift while `cp_up_i` is high. A falling edge on `cp_dn_i` while `cp_up_i` is low causes none. A rising edge on `cp_dn_i` never causes a shift.
- R5: Each shift moves every stored bit one stage toward the output. Between shifts the output holds its value.
- R6: While `mclr_i` is high, `q_o` is 0 and `qn_o` is 1 in the same cycle, whatever the other inputs are. Every stage is cleared.
- R7: `qn_o` is always the complement of `q_o`.
- R8: Changing the length code between shifts moves the output tap at once. No stored data is lost, because stages beyond the selected length keep shifting.
- R9: No shift takes place while a clear is active, nor in the cycles right after `mclr_i` or `rst_n` is released, even if a qualifier pin is already in its active state.
- R10: After a system reset through `rst_n`, the register is empty and `q_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| mclr_i | input | 1 | Master clear, active high, takes effect immediately |
| len_i | input | 6 | Length code; active length is len_i + 1 |
| src_sel_i | input | 1 | Serial source select: 0 picks din_a_i, 1 picks din_b_i |
| din_a_i | input | 1 | Serial data input A |
| din_b_i | input | 1 | Serial data input B (recirculation path) |
| cp_up_i | input | 1 | Shift qualifier that acts on its rising edge |
| cp_dn_i | input | 1 | Shift qualifier that acts on its falling edge |
| q_o | output | 1 | Serial output, taken at the selected length |
| qn_o | output | 1 | Complement of q_o |

## Verification
The assertions check, on every cycle, the behaviour that can be seen directly:
- the clear forcing the outputs;
- the outputs staying complementary;
- no shift occurring during a clear;
- the first stage taking the selected source;
- the output holding steady when there is no shift and no length change.

Other behaviours only show up over a sequence of events, so the directed scenarios cover them:
- the exact shift count for short, medium and full lengths;
- the gating between the two qualifier pins;
- preservation of data when the length changes;
- recirculation through the B input;
- the absence of a spurious shift when a qualifier pin is held active across a clear release.

// File: rtl/plsr_pkg.sv
// Shared constants and types for the programmable-length shift register.
// Assumes a maximum length that is a power of two so every code is valid.
package plsr_pkg;
    localparam int unsigned PLSR_MAX_LEN     = 64;
    localparam int unsigned PLSR_LEN_W       = $clog2(PLSR_MAX_LEN);
    localparam int unsigned PLSR_SYNC_STAGES = 2;

    typedef logic [PLSR_LEN_W-1:0] plsr_len_t;
endpackage

// File: rtl/plsr_sync_bit.sv
// Multi-flop synchronizer for one asynchronous level.
// Assumes STAGES >= 2; resets all flops to 0.
module plsr_sync_bit #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_q;

    // Shift the asynchronous level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], async_i};
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/plsr_clr_ctrl.sv
// Clear control: the master clear acts at once, and its release is stretched
// by HOLD cycles so the qualifier pipelines refill before shifting resumes.
// A system reset behaves as a clear that is just being released.
module plsr_clr_ctrl #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mclr_i,
    output logic clear_o
);
    localparam int unsigned HOLD = SYNC_STAGES + 1;

    logic [HOLD-1:0] hold_q;

    // Load the stretch pipe on clear or reset, then drain it with zeros.
    always_ff @(posedge clk) begin
        if (!rst_n || mclr_i) hold_q <= '1;
        else                  hold_q <= {hold_q[HOLD-2:0], 1'b0};
    end

    assign clear_o = mclr_i | hold_q[HOLD-1];
endmodule

// File: rtl/plsr_strobe_gen.sv
// Turns the two qualifier pins into a single-cycle shift request.
// Index 0 acts on its rising edge while index 1 is low; index 1 acts on its
// falling edge while index 0 is high. Both conditions together still give
// one request. Assumes the pins are stable for more than SYNC_STAGES cycles.
module plsr_strobe_gen #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] cp_i,
    output logic       strobe_o
);
    logic [1:0] cp_s;
    logic [1:0] cp_d;
    logic       up_rise;
    logic       dn_fall;

    for (genvar g = 0; g < 2; g++) begin : g_sync
        plsr_sync_bit #(.STAGES(SYNC_STAGES)) u_sync (
            .clk    (clk),
            .rst_n  (rst_n),
            .async_i(cp_i[g]),
            .sync_o (cp_s[g])
        );
    end

    // Keep the previous synchronized levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) cp_d <= '0;
        else        cp_d <= cp_s;
    end

    // Qualify each edge with the other pin's current level.
    always_comb begin
        up_rise  = cp_s[0] & ~cp_d[0] & ~cp_s[1];
        dn_fall  = ~cp_s[1] & cp_d[1] & cp_s[0];
        strobe_o = up_rise | dn_fall;
    end
endmodule

// File: rtl/plsr_stage_chain.sv
// Full-depth storage chain with a length-selected output tap.
// Every stage always shifts; the tap index picks the active length, so a
// length change never drops data. Clear empties the chain synchronously.
module plsr_stage_chain #(
    parameter int unsigned DEPTH = 64,
    parameter int unsigned LEN_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             shift_i,
    input  logic             din_i,
    input  logic [LEN_W-1:0] tap_i,
    output logic             tap_o,
    output logic             head_o
);
    logic [DEPTH-1:0] stage_q;

    // Move all bits one stage toward the end on each shift request.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) stage_q <= '0;
        else if (shift_i)      stage_q <= {stage_q[DEPTH-2:0], din_i};
    end

    assign tap_o  = stage_q[tap_i];
    assign head_o = stage_q[0];
endmodule

// File: rtl/prog_len_shreg.sv
// Programmable-length serial shift register, 1 to MAX_LEN bits.
// Assumes the data and select inputs stay stable from a qualifier edge until
// the shift that edge produces (SYNC_STAGES + 1 system clocks).
module prog_len_shreg
    import plsr_pkg::*;
#(
    parameter int unsigned MAX_LEN     = PLSR_MAX_LEN,
    parameter int unsigned SYNC_STAGES = PLSR_SYNC_STAGES,
    localparam int unsigned LEN_W      = $clog2(MAX_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mclr_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic             src_sel_i,
    input  logic             din_a_i,
    input  logic             din_b_i,
    input  logic             cp_up_i,
    input  logic             cp_dn_i,
    output logic             q_o,
    output logic             qn_o
);
    logic clear_act;
    logic strobe;
    logic shift_en;
    logic serial_in;
    logic tap_bit;
    logic chain_head;

    plsr_clr_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_clr (
        .clk    (clk),
        .rst_n  (rst_n),
        .mclr_i (mclr_i),
        .clear_o(clear_act)
    );

    plsr_strobe_gen #(.SYNC_STAGES(SYNC_STAGES)) u_stb (
        .clk     (clk),
        .rst_n   (rst_n),
        .cp_i    ({cp_dn_i, cp_up_i}),
        .strobe_o(strobe)
    );

    // Block shifts during a clear and while its release is being stretched.
    assign shift_en  = strobe & ~clear_act;
    // Pick the serial source for recirculation or fresh data.
    assign serial_in = src_sel_i ? din_b_i : din_a_i;

    plsr_stage_chain #(.DEPTH(MAX_LEN), .LEN_W(LEN_W)) u_chain (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear_i(clear_act),
        .shift_i(shift_en),
        .din_i  (serial_in),
        .tap_i  (len_i),
        .tap_o  (tap_bit),
        .head_o (chain_head)
    );

    // Force the outputs while clearing; otherwise drive the selected tap.
    always_comb begin
        q_o  = clear_act ? 1'b0 : tap_bit;
        qn_o = clear_act ? 1'b1 : ~tap_bit;
    end
endmodule

// File: rtl/plsr_checker.sv
// Property checker for prog_len_shreg, attached through bind.
module plsr_checker #(
    parameter int unsigned LEN_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mclr_i,
    input logic [LEN_W-1:0] len_i,
    input logic             src_sel_i,
    input logic             din_a_i,
    input logic             din_b_i,
    input logic             q_o,
    input logic             qn_o,
    input logic             shift_en,
    input logic             clear_act,
    input logic             chain_head
);
    AST_CLEAR_FORCES_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        mclr_i |-> (!q_o && qn_o)); // R6

    AST_OUT_COMPLEMENT: assert property (@(posedge clk) disable iff (!rst_n)
        qn_o != q_o); // R7

    AST_NO_SHIFT_IN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clear_act |-> !shift_en); // R9

    AST_SOURCE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (chain_head == $past(src_sel_i ? din_b_i : din_a_i))); // R2

    AST_HOLD_BETWEEN_SHIFTS: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_act && !$past(clear_act) && !$past(shift_en) && $stable(len_i))
        |-> $stable(q_o)); // R5
endmodule

bind prog_len_shreg plsr_checker #(.LEN_W(LEN_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mclr_i    (mclr_i),
    .len_i     (len_i),
    .src_sel_i (src_sel_i),
    .din_a_i   (din_a_i),
    .din_b_i   (din_b_i),
    .q_o       (q_o),
    .qn_o      (qn_o),
    .shift_en  (shift_en),
    .clear_act (clear_act),
    .chain_head(chain_head)
);

// File: tb/sim_prog_len_shreg.sv
`timescale 1ns/1ps
module sim_prog_len_shreg;
    localparam real HALF = 2.5;
    localparam int  SETTLE = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mclr = 1'b0;
    logic [5:0] len = '0;
    logic       sel = 1'b0;
    logic       da = 1'b0;
    logic       db = 1'b0;
    logic       cpu = 1'b0;
    logic       cpd = 1'b0;
    logic       q;
    logic       qn;

    int         n_vec = 0;
    int         n_bad = 0;
    logic [63:0] mdl = '0;

    always #(HALF) clk = ~clk;

    prog_len_shreg u0 (
        .clk(clk), .rst_n(rst_n), .mclr_i(mclr), .len_i(len),
        .src_sel_i(sel), .din_a_i(da), .din_b_i(db),
        .cp_up_i(cpu), .cp_dn_i(cpd), .q_o(q), .qn_o(qn)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic chk_out(input string req);
        chk(req, q, mdl[len]);
        chk({req, " R7"}, qn, ~mdl[len]);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One shift through the rising edge of cp_up with cp_dn low.
    task automatic shift_up(input logic bit_v, input logic use_b);
        sel = use_b;
        if (use_b) begin db = bit_v; da = ~bit_v; end
        else       begin da = bit_v; db = ~bit_v; end
        cpu = 1'b1; idle(SETTLE);
        mdl = {mdl[62:0], bit_v};
        cpu = 1'b0; idle(SETTLE);
    endtask

    // One shift through the falling edge of cp_dn with cp_up high; the other
    // three transitions in the sequence must not shift.
    task automatic shift_dn(input logic bit_v);
        sel = 1'b0; da = bit_v;
        cpd = 1'b1; idle(SETTLE); chk_out("R4 dn rise no shift");
        cpu = 1'b1; idle(SETTLE); chk_out("R3 up rise gated by dn high");
        cpd = 1'b0; idle(SETTLE);
        mdl = {mdl[62:0], bit_v};
        chk_out("R4 dn fall with up high");
        cpu = 1'b0; idle(SETTLE); chk_out("R3 up fall no shift");
    endtask

    task automatic do_clear();
        mclr = 1'b1; #1;
        chk("R6 q low at clear", q, 1'b0);
        chk("R6 qn high at clear", qn, 1'b1);
        idle(2);
        mclr = 1'b0; idle(SETTLE);
        mdl = '0;
    endtask

    task automatic t_reset();
        idle(1);
        chk("R10 q after reset", q, 1'b0);
        chk("R10 R7 qn after reset", qn, 1'b1);
    endtask

    task automatic t_len_one();
        len = 6'd0;
        shift_up(1'b1, 1'b0); chk_out("R1 len1 one");
        shift_up(1'b0, 1'b0); chk_out("R1 len1 zero");
    endtask

    task automatic t_len_six();
        do_clear();
        len = 6'd5;
        shift_up(1'b1, 1'b0);
        for (int i = 1; i < 6; i++) begin
            chk_out("R1 len6 before arrival");
            chk("R1 len6 not yet", q, 1'b0);
            shift_up(1'b0, 1'b0);
        end
        chk("R1 len6 arrives after six", q, 1'b1);
        shift_up(1'b0, 1'b0); chk_out("R5 len6 moves on");
    endtask

    task automatic t_len_full();
        do_clear();
        len = 6'd63;
        shift_up(1'b1, 1'b0);
        for (int i = 1; i < 64; i++) begin
            if (i == 63) chk("R1 len64 one short", q, 1'b0);
            shift_up(1'b0, 1'b0);
        end
        chk("R1 len64 arrives", q, 1'b1);
    endtask

    task automatic t_select();
        do_clear();
        len = 6'd0;
        shift_up(1'b1, 1'b1); chk_out("R2 source B one");
        shift_up(1'b0, 1'b1); chk_out("R2 source B zero");
        shift_up(1'b1, 1'b0); chk_out("R2 source A one");
    endtask

    task automatic t_dn_path();
        do_clear();
        len = 6'd1;
        shift_dn(1'b1);
        shift_dn(1'b0);
        chk("R4 two dn shifts len2", q, 1'b1);
    endtask

    task automatic t_len_change();
        do_clear();
        len = 6'd2;
        shift_up(1'b1, 1'b0); shift_up(1'b1, 1'b0); shift_up(1'b0, 1'b0);
        shift_up(1'b1, 1'b0); shift_up(1'b0, 1'b0);
        for (int k = 0; k < 8; k++) begin
            len = 6'(k); #1;
            chk_out("R8 tap moves at once");
        end
        len = 6'd4; shift_up(1'b0, 1'b0); chk_out("R8 deep data kept");
    endtask

    task automatic t_recirc();
        do_clear();
        len = 6'd3;
        shift_up(1'b1, 1'b0); shift_up(1'b0, 1'b0);
        shift_up(1'b1, 1'b0); shift_up(1'b1, 1'b0);
        for (int i = 0; i < 8; i++) begin
            shift_up(q, 1'b1);
            chk_out("R2 R5 recirculate");
        end
    endtask

    task automatic t_no_spurious();
        len = 6'd0; da = 1'b1; sel = 1'b0;
        mclr = 1'b1; idle(1);
        cpu = 1'b1; idle(SETTLE);
        mclr = 1'b0; idle(SETTLE);
        mdl = '0;
        chk("R9 no shift after clear release", q, 1'b0);
        cpu = 1'b0; idle(SETTLE);
        rst_n = 1'b0; cpu = 1'b1; idle(3);
        rst_n = 1'b1; idle(SETTLE);
        chk("R9 R10 no shift after reset release", q, 1'b0);
        cpu = 1'b0; idle(SETTLE);
        shift_up(1'b1, 1'b0); chk_out("R9 shifting resumes");
    endtask

    initial begin
        #(HALF * 2 * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        idle(4);
        rst_n = 1'b1;
        idle(SETTLE);
        t_reset();
        t_len_one();
        t_len_six();
        t_len_full();
        t_select();
        t_dn_path();
        t_len_change();
        t_recirc();
        t_no_spurious();
        do_clear();
        chk_out("R6 cleared state");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule